// File: doc/BRIEF.md
# Line-Rate and Tri-Level Sync Format Detector

This block sits behind a pair of sync level slicers and works out what kind of video timing is arriving. It sees two clocked comparator bits: one that is high while the input is below blanking (the negative sync tip) and one that is high while the input is above blanking (the positive half of a tri-level sync). From the spacing of sync leading edges it takes a line period, and from whether a positive excursion directly follows each negative pulse it tells tri-level from bi-level sync. The result is a format class for neighbouring blocks, a lock indication, and an active-low HD flag that can switch an external SD-only chroma filter out of the path.

Classification follows the input by itself. A new candidate class must hold for a set number of consecutive lines before it is committed. If sync edges stop for longer than a timeout, the block drops lock and starts qualifying again. No reset or setting is needed. Four lock states drive this: SEARCH (no class yet), QUALIFY (first candidate seen, waiting for it to persist), LOCKED (class committed) and SWITCHING (locked class no longer matches the candidate, old class held). The transitions are:
- SEARCH→QUALIFY on the first measured line.
- QUALIFY→LOCKED when the candidate is stable.
- LOCKED→SWITCHING when a line's candidate differs from the committed class.
- SWITCHING→LOCKED when a candidate is stable, committing that candidate.
- Any state→SEARCH on sync loss.

Top module: `sync_format_detector`

## Requirements
- R1: After reset `fmt_class_o` is 0 (none), `locked_o` is 0 and `hd_flag_n_o` is 1.
- R2: The class codes on `fmt_class_o` are 0 none, 1 SD, 2 ED, 3 HD, 4 PC/other. Bi-level sync with a line period of at most HD_LINE_MAX cycles settles to class 4 with `hd_flag_n_o` high.
- R3: Bi-level sync with a period above HD_LINE_MAX and at most ED_LINE_MAX cycles settles to class 2.
- R4: A period above ED_LINE_MAX and at most SD_LINE_MAX settles to class 1. A period above SD_LINE_MAX but shorter than the timeout settles to class 4.
- R5: A line counts as tri-level when `sync_above_i` is high within TRI_WIN cycles after `sync_below_i` falls. After TRI_LINES consecutive tri-level lines with a period of at most ED_LINE_MAX, the block commits class 3. `hd_flag_n_o` is low only while locked with class 3.
- R6: While fewer than TRI_LINES consecutive tri-level lines have been seen, `hd_flag_n_o` stays high.
- R7: A positive excursion that starts later than TRI_WIN cycles after the negative pulse ends does not count as tri-level, so the flag stays high.
- R8: Tri-level sync with a period above ED_LINE_MAX is classed by period (SD) and keeps the flag high.
- R9: A candidate class is committed only after PERSIST_LINES consecutive lines agree. While a change is pending, `locked_o` is 0, `hd_flag_n_o` is 1 and `fmt_class_o` holds the old class.
- R10: When no sync leading edge arrives for TIMEOUT_CYC cycles, the block reports class 0, `locked_o` 0 and flag high, then relocks on resumed sync without a reset.
- R11: A change of format while locked is followed to the new class with no reset.
- R12: While `locked_o` stays high on consecutive cycles, `fmt_class_o` does not change, and lock is gained only on a measured line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_below_i | input | 1 | Slicer bit, high while input is below blanking |
| sync_above_i | input | 1 | Slicer bit, high while input is above blanking during sync |
| hd_flag_n_o | output | 1 | Low only while locked to qualified tri-level HD |
| fmt_class_o | output | 3 | Committed class: 0 none, 1 SD, 2 ED, 3 HD, 4 PC/other |
| locked_o | output | 1 | High while a class is committed and current |

## Verification
The assertions assume that both slicer bits are already clean and synchronous to `clk`. They also assume that each negative pulse is long enough for its leading and trailing edges to fall in separate cycles, and that the positive half of a tri-level sync never overlaps the negative half. The stimulus generates every line from a fixed pattern: a six-cycle negative pulse, then an optional four-cycle positive pulse placed either directly after it or well past the window. Line lengths are chosen to sit clearly inside one period bin and below the timeout, except in the deliberate idle gap.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    typedef enum logic [2:0] {
        FMT_NONE = 3'd0,
        FMT_SD   = 3'd1,
        FMT_ED   = 3'd2,
        FMT_HD   = 3'd3,
        FMT_PC   = 3'd4
    } fmt_e;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_QUAL   = 2'd1,
        ST_LOCK   = 2'd2,
        ST_SWITCH = 2'd3
    } lock_state_e;

endpackage

// File: rtl/sfd_line_timer.sv
module sfd_line_timer #(
    parameter int TIMEOUT_CYC = 56000,
    parameter int TRI_WIN     = 64,
    localparam int CW = $clog2(TIMEOUT_CYC + 1),
    localparam int WW = $clog2(TRI_WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          below_i,
    input  logic          above_i,
    output logic          line_ev_o,
    output logic [CW-1:0] line_per_o,
    output logic          line_tri_o,
    output logic          sync_lost_o
);

    localparam logic [CW-1:0] TO_VAL  = CW'(TIMEOUT_CYC);
    localparam logic [WW-1:0] WIN_END = WW'(TRI_WIN - 1);

    logic          below_q, below_qq, above_q;
    logic [CW-1:0] cnt;
    logic [WW-1:0] wcnt;
    logic          armed;
    logic          tri_cur;
    logic          rise, fall;

    assign rise = below_q & ~below_qq;
    assign fall = ~below_q & below_qq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            below_q  <= 1'b0;
            below_qq <= 1'b0;
            above_q  <= 1'b0;
            cnt      <= TO_VAL;
            wcnt     <= '0;
            armed    <= 1'b0;
            tri_cur  <= 1'b0;
        end else begin
            below_q  <= below_i;
            below_qq <= below_q;
            above_q  <= above_i;

            // period counter saturates at the timeout value
            if (rise) begin
                cnt <= CW'(1);
            end else if (cnt != TO_VAL) begin
                cnt <= cnt + CW'(1);
            end

            // window after the end of the negative pulse
            if (fall) begin
                armed <= 1'b1;
                wcnt  <= '0;
            end else if (armed) begin
                if (wcnt == WIN_END) begin
                    armed <= 1'b0;
                end
                wcnt <= wcnt + WW'(1);
            end

            if (rise) begin
                tri_cur <= 1'b0;
            end else if ((fall || armed) && above_q) begin
                tri_cur <= 1'b1;
            end
        end
    end

    assign line_ev_o   = rise && (cnt != TO_VAL);
    assign line_per_o  = cnt;
    assign line_tri_o  = tri_cur;
    assign sync_lost_o = (cnt == TO_VAL);

endmodule

// File: rtl/sfd_classifier.sv
module sfd_classifier
    import sfd_pkg::*;
#(
    parameter int CW            = 16,
    parameter int HD_LINE_MAX   = 6100,
    parameter int ED_LINE_MAX   = 7000,
    parameter int SD_LINE_MAX   = 14000,
    parameter int TRI_LINES     = 16,
    parameter int PERSIST_LINES = 4,
    localparam int TW = $clog2(TRI_LINES + 1),
    localparam int PW = $clog2(PERSIST_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_ev_i,
    input  logic [CW-1:0] line_per_i,
    input  logic          line_tri_i,
    input  logic          sync_lost_i,
    output fmt_e          cand_o,
    output logic          stable_o,
    output logic          tri_ok_o
);

    localparam logic [TW-1:0] TRI_SAT = TW'(TRI_LINES);
    localparam logic [PW-1:0] PER_SAT = PW'(PERSIST_LINES);

    logic [TW-1:0] tri_run, tri_next;
    logic [PW-1:0] run, run_next;
    fmt_e          last_cand;
    fmt_e          cand;
    logic          tri_qual;

    always_comb begin
        if (!line_tri_i) begin
            tri_next = '0;
        end else if (tri_run == TRI_SAT) begin
            tri_next = tri_run;
        end else begin
            tri_next = tri_run + TW'(1);
        end
        tri_qual = (tri_next == TRI_SAT);

        if (tri_qual && (line_per_i <= CW'(ED_LINE_MAX))) begin
            cand = FMT_HD;
        end else if (line_per_i <= CW'(HD_LINE_MAX)) begin
            cand = FMT_PC;
        end else if (line_per_i <= CW'(ED_LINE_MAX)) begin
            cand = FMT_ED;
        end else if (line_per_i <= CW'(SD_LINE_MAX)) begin
            cand = FMT_SD;
        end else begin
            cand = FMT_PC;
        end

        if (cand != last_cand) begin
            run_next = PW'(1);
        end else if (run == PER_SAT) begin
            run_next = run;
        end else begin
            run_next = run + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tri_run   <= '0;
            run       <= '0;
            last_cand <= FMT_NONE;
        end else if (sync_lost_i) begin
            tri_run   <= '0;
            run       <= '0;
            last_cand <= FMT_NONE;
        end else if (line_ev_i) begin
            tri_run   <= tri_next;
            run       <= run_next;
            last_cand <= cand;
        end
    end

    assign cand_o   = cand;
    assign stable_o = (run_next == PER_SAT);
    assign tri_ok_o = (tri_run == TRI_SAT);

    // R7
    bilevel_clears_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ev_i && !line_tri_i) |=> !tri_ok_o);

endmodule

// File: rtl/sfd_lock_fsm.sv
module sfd_lock_fsm
    import sfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_ev_i,
    input  fmt_e cand_i,
    input  logic stable_i,
    input  logic sync_lost_i,
    output logic hd_flag_n_o,
    output fmt_e fmt_o,
    output logic locked_o
);

    lock_state_e state, state_n;
    fmt_e        cls, cls_n;

    always_comb begin
        state_n = state;
        cls_n   = cls;
        unique case (state)
            ST_SEARCH: begin
                if (line_ev_i) begin
                    state_n = ST_QUAL;
                end
            end
            ST_QUAL: begin
                if (line_ev_i && stable_i) begin
                    state_n = ST_LOCK;
                    cls_n   = cand_i;
                end
            end
            ST_LOCK: begin
                if (line_ev_i && (cand_i != cls)) begin
                    state_n = ST_SWITCH;
                end
            end
            ST_SWITCH: begin
                if (line_ev_i && stable_i) begin
                    state_n = ST_LOCK;
                    cls_n   = cand_i;
                end
            end
            default: begin
                state_n = ST_SEARCH;
                cls_n   = FMT_NONE;
            end
        endcase
        if (sync_lost_i) begin
            state_n = ST_SEARCH;
            cls_n   = FMT_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SEARCH;
            cls   <= FMT_NONE;
        end else begin
            state <= state_n;
            cls   <= cls_n;
        end
    end

    always_comb begin
        locked_o    = (state == ST_LOCK);
        fmt_o       = cls;
        hd_flag_n_o = !((state == ST_LOCK) && (cls == FMT_HD));
    end

    // R10
    lost_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost_i |=> !locked_o);

    // R12
    class_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && $past(locked_o)) |-> (fmt_o == $past(fmt_o)));

    // R12
    lock_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(line_ev_i));

endmodule

// File: rtl/sync_format_detector.sv
module sync_format_detector
    import sfd_pkg::*;
#(
    parameter int HD_LINE_MAX   = 6100,
    parameter int ED_LINE_MAX   = 7000,
    parameter int SD_LINE_MAX   = 14000,
    parameter int TIMEOUT_CYC   = 56000,
    parameter int TRI_WIN       = 64,
    parameter int TRI_LINES     = 16,
    parameter int PERSIST_LINES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_below_i,
    input  logic       sync_above_i,
    output logic       hd_flag_n_o,
    output logic [2:0] fmt_class_o,
    output logic       locked_o
);

    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    logic          line_ev;
    logic [CW-1:0] line_per;
    logic          line_tri;
    logic          sync_lost;
    fmt_e          cand;
    logic          stable;
    logic          tri_ok;
    fmt_e          fmt;

    sfd_line_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .TRI_WIN     (TRI_WIN)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .below_i     (sync_below_i),
        .above_i     (sync_above_i),
        .line_ev_o   (line_ev),
        .line_per_o  (line_per),
        .line_tri_o  (line_tri),
        .sync_lost_o (sync_lost)
    );

    sfd_classifier #(
        .CW            (CW),
        .HD_LINE_MAX   (HD_LINE_MAX),
        .ED_LINE_MAX   (ED_LINE_MAX),
        .SD_LINE_MAX   (SD_LINE_MAX),
        .TRI_LINES     (TRI_LINES),
        .PERSIST_LINES (PERSIST_LINES)
    ) u_class (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_ev_i   (line_ev),
        .line_per_i  (line_per),
        .line_tri_i  (line_tri),
        .sync_lost_i (sync_lost),
        .cand_o      (cand),
        .stable_o    (stable),
        .tri_ok_o    (tri_ok)
    );

    sfd_lock_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_ev_i   (line_ev),
        .cand_i      (cand),
        .stable_i    (stable),
        .sync_lost_i (sync_lost),
        .hd_flag_n_o (hd_flag_n_o),
        .fmt_o       (fmt),
        .locked_o    (locked_o)
    );

    assign fmt_class_o = fmt;

    // R5
    hd_needs_tri_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hd_flag_n_o) |-> tri_ok);

endmodule

// File: tb/sync_format_detector_bench.sv
module sync_format_detector_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       below = 1'b0;
    logic       above = 1'b0;
    logic       hd_n;
    logic [2:0] fmt;
    logic       locked;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    localparam int L_HD = 30, L_ED = 60, L_SD = 120, L_LONG = 200;

    always #2.5 clk = ~clk;

    sync_format_detector #(
        .HD_LINE_MAX   (40),
        .ED_LINE_MAX   (80),
        .SD_LINE_MAX   (160),
        .TIMEOUT_CYC   (400),
        .TRI_WIN       (8),
        .TRI_LINES     (16),
        .PERSIST_LINES (4)
    ) u_sync_format_detector (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_below_i (below),
        .sync_above_i (above),
        .hd_flag_n_o  (hd_n),
        .fmt_class_o  (fmt),
        .locked_o     (locked)
    );

    // mode: 0 bi-level, 1 tri-level, 2 late positive pulse
    task automatic send_line(input int len, input int mode);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            below = (i < 6);
            if (mode == 1)      above = (i >= 6) && (i < 10);
            else if (mode == 2) above = (i >= 18) && (i < 22);
            else                above = 1'b0;
        end
    endtask

    task automatic send_lines(input int n, input int len, input int mode);
        for (int k = 0; k < n; k++) send_line(len, mode);
    endtask

    task automatic check(input string req, input logic [2:0] ef,
                         input logic el, input logic eh);
        tests++;
        if (fmt !== ef || locked !== el || hd_n !== eh) begin
            fails++;
            $display("FAIL %s: fmt/locked/hd_n actual %0d/%0b/%0b expected %0d/%0b/%0b",
                     req, fmt, locked, hd_n, ef, el, eh);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", 3'd0, 1'b0, 1'b1);
    endtask

    task automatic t_sd();
        send_lines(12, L_SD, 0);
        check("R4 sd", 3'd1, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            send_line(L_SD, 0);
            check("R12 steady", 3'd1, 1'b1, 1'b1);
        end
    endtask

    task automatic t_ed();
        send_lines(12, L_ED, 0);
        check("R3 R11 ed", 3'd2, 1'b1, 1'b1);
    endtask

    task automatic t_pc();
        send_lines(12, L_HD, 0);
        check("R2 pc", 3'd4, 1'b1, 1'b1);
    endtask

    task automatic t_hd();
        send_lines(8, L_HD, 1);
        check("R6 qualifying", 3'd4, 1'b1, 1'b1);
        send_lines(20, L_HD, 1);
        check("R5 hd", 3'd3, 1'b1, 1'b0);
    endtask

    task automatic t_hd_to_bi();
        send_lines(2, L_HD, 0);
        check("R9 pending", 3'd3, 1'b0, 1'b1);
        send_lines(8, L_HD, 0);
        check("R11 hd to pc", 3'd4, 1'b1, 1'b1);
    endtask

    task automatic t_late();
        send_lines(25, L_HD, 2);
        check("R7 late", 3'd4, 1'b1, 1'b1);
    endtask

    task automatic t_tri_slow();
        send_lines(25, L_SD, 1);
        check("R8 slow tri", 3'd1, 1'b1, 1'b1);
    endtask

    task automatic t_long();
        send_lines(12, L_LONG, 0);
        check("R4 long", 3'd4, 1'b1, 1'b1);
    endtask

    task automatic t_lost();
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            below = 1'b0;
            above = 1'b0;
        end
        check("R10 lost", 3'd0, 1'b0, 1'b1);
        send_lines(12, L_SD, 0);
        check("R10 relock", 3'd1, 1'b1, 1'b1);
    endtask

    task automatic t_persist();
        send_lines(2, L_ED, 0);
        check("R9 hold", 3'd1, 1'b0, 1'b1);
        send_lines(8, L_ED, 0);
        check("R9 commit", 3'd2, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_sd();
        t_ed();
        t_pc();
        t_hd();
        t_hd_to_bi();
        t_late();
        t_tri_slow();
        t_long();
        t_lost();
        t_persist();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule